// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit buses, A and B, with two independent one-way paths, A-to-B and B-to-A. No bit is inverted on either path. Each path has one storage cell. The cell's own latch-enable and capture-clock pins select how it behaves. It can pass data straight through, hold a captured word, or capture a new word on a rising capture-clock level change. The A-to-B output enable is active high. The B-to-A output enable is active low.

The block runs on a single system clock. The capture-clock pins are sampled on that clock, and a rise is detected between two consecutive samples.

Each pad is modelled as a data vector plus a drive-enable flag. When nothing drives an input bus, a bus-hold register supplies the last level that was driven onto that bus.

If both paths are enabled at the same time, the block does not settle the conflict. It raises a contention flag instead.

Top module: `xcvr_universal`

## Requirements
- R1: Both paths carry all 18 bits without inversion. Bit i of the source bus appears as bit i of the destination output.
- R2: While `ab_pass` is 1 and `ab_oe` is 1, `b_drv` equals the effective A value in the same cycle, with no clock delay.
- R3: While `ab_pass` is 0 and `ab_cap` shows no rise, `b_drv` keeps the stored word, whatever the A bus does.
- R4: With `ab_pass` at 0, a clock edge where `ab_cap` is 1 and was 0 at the previous edge stores the effective A value. `b_drv` shows that value from the next cycle on.
- R5: A fall of `ab_cap` (1 then 0) leaves the stored word unchanged.
- R6: `ab_oe` is active high. While it is 0, `b_drv_en` is 0 and `b_drv` reads all zeros.
- R7: The B-to-A path follows R2 to R5 with `ba_pass` and `ba_cap`. Its enable `ba_oe_n` is active low: `a_drv_en` is 1 only while `ba_oe_n` is 0.
- R8: While `a_in_en` (or `b_in_en`) is 0, the effective input value is the last value seen on `a_in` (or `b_in`) while its enable was 1.
- R9: Storage keeps capturing while its output is disabled. When the output is re-enabled, it shows the word captured during the disabled time.
- R10: While `rst_n` is low at a clock edge, both storage cells and both bus-hold registers are cleared to zero.
- R11: `contention` is 1 exactly when `ab_oe` is 1 and `ba_oe_n` is 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_pass | input | 1 | A-to-B latch enable (1 = pass-through) |
| ab_cap | input | 1 | A-to-B capture clock level |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A latch enable (1 = pass-through) |
| ba_cap | input | 1 | B-to-A capture clock level |
| a_in | input | 18 | Value driven onto bus A from outside |
| a_in_en | input | 1 | Bus A is driven from outside |
| b_in | input | 18 | Value driven onto bus B from outside |
| b_in_en | input | 1 | Bus B is driven from outside |
| a_drv | output | 18 | Value this block drives onto bus A |
| a_drv_en | output | 1 | This block drives bus A |
| b_drv | output | 18 | Value this block drives onto bus B |
| b_drv_en | output | 1 | This block drives bus B |
| contention | output | 1 | Both paths are enabled at once |

## Verification
The bench walks a one through every bit position, and checks pass-through on many words in both directions. A swapped or inverted bit fails these checks at once.

It then steps each cell through a fixed sequence: pass, hold, rise capture, held level, and fall. A design that captures on the fall, or on every cycle the capture pin is high, shows a changed word at the held-level or fall step.

Further steps exercise three more cases. Capture while the output is disabled catches a design that gates storage with the enable. Release of a driven bus catches a missing bus-hold, which would pass the stray undriven value. All four enable combinations catch swapped enable polarities and a wrong contention term.

// File: rtl/xcvr_pkg.sv
// Package: shared width default and the storage-cell mode type.
// Assumes: every module in the transceiver imports this package.
package xcvr_pkg;
    parameter int XCVR_WIDTH = 18;

    typedef enum logic [1:0] {
        CELL_PASS = 2'd0,
        CELL_HOLD = 2'd1,
        CELL_LOAD = 2'd2
    } cell_mode_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
// Bus-hold keeper for one input bus.
// What it does: while the bus is driven from outside, it passes that value
// through and also stores it. While the bus is undriven, it returns the
// stored value.
// Assumes: synchronous active-low reset clears the kept level to zero.
module xcvr_bus_hold
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         bus_driven,
    output logic [W-1:0] bus_eff
);
    logic [W-1:0] kept_q;

    // Store the last level that was driven onto the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kept_q <= '0;
        else if (bus_driven)
            kept_q <= bus_in;
    end

    // Choose the live bus value or the kept level.
    always_comb begin
        bus_eff = bus_driven ? bus_in : kept_q;
    end
endmodule

// File: rtl/xcvr_store_cell.sv
// Storage cell for one direction: one element that acts as latch or register.
// What it does:
//   - pass is 1: the cell is transparent, and the input also writes storage.
//   - pass is 0, cap rises: the input is captured.
//   - otherwise: the stored word is held.
// Assumes: cap is a level sampled on clk, and a rise is judged between
// consecutive samples.
module xcvr_store_cell
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic         cap_prev;
    logic [W-1:0] word_q;
    cell_mode_t   mode;

    // Track the previous sample of the capture pin (not storage, so not reset).
    always_ff @(posedge clk) begin
        cap_prev <= cap;
    end

    // Decode the operating mode from the latch enable and the capture rise.
    always_comb begin
        if (pass)
            mode = CELL_PASS;
        else if (cap && !cap_prev)
            mode = CELL_LOAD;
        else
            mode = CELL_HOLD;
    end

    // Update the stored word in pass and load modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (mode != CELL_HOLD)
            word_q <= din;
    end

    // Present the live input while transparent, else the stored word.
    always_comb begin
        dout = (mode == CELL_PASS) ? din : word_q;
    end
endmodule

// File: rtl/xcvr_out_stage.sv
// Output stage for one direction: turns an enable pin of either polarity
// into a pad drive-enable. Data is forced to zero while the pad is released.
// Assumes: EN_HIGH = 1 means the enable pin is active high.
module xcvr_out_stage
    import xcvr_pkg::*;
#(
    parameter int W       = XCVR_WIDTH,
    parameter bit EN_HIGH = 1'b1
) (
    input  logic         oe_pin,
    input  logic [W-1:0] data,
    output logic [W-1:0] pad_data,
    output logic         pad_en
);
    logic active;

    // Resolve the enable pin polarity chosen at elaboration.
    generate
        if (EN_HIGH) begin : g_high
            assign active = oe_pin;
        end else begin : g_low
            assign active = ~oe_pin;
        end
    endgenerate

    // Drive the pad only while enabled.
    always_comb begin
        pad_en   = active;
        pad_data = active ? data : '0;
    end
endmodule

// File: rtl/xcvr_universal.sv
// Top: bidirectional latch/register bus transceiver.
// What it does: for each direction, a bus-hold keeper on the source bus feeds
// a storage cell, and the cell feeds an output stage. The A-to-B enable is
// active high; the B-to-A enable is active low. A flag reports when both
// directions drive at once.
// Assumes: a single system clock and a synchronous active-low reset.
module xcvr_universal
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe,
    input  logic         ab_pass,
    input  logic         ab_cap,
    input  logic         ba_oe_n,
    input  logic         ba_pass,
    input  logic         ba_cap,
    input  logic [W-1:0] a_in,
    input  logic         a_in_en,
    input  logic [W-1:0] b_in,
    input  logic         b_in_en,
    output logic [W-1:0] a_drv,
    output logic         a_drv_en,
    output logic [W-1:0] b_drv,
    output logic         b_drv_en,
    output logic         contention
);
    logic [W-1:0] a_eff, b_eff, ab_word, ba_word;

    xcvr_bus_hold #(.W(W)) u_hold_a (
        .clk(clk), .rst_n(rst_n), .bus_in(a_in), .bus_driven(a_in_en), .bus_eff(a_eff)
    );

    xcvr_bus_hold #(.W(W)) u_hold_b (
        .clk(clk), .rst_n(rst_n), .bus_in(b_in), .bus_driven(b_in_en), .bus_eff(b_eff)
    );

    xcvr_store_cell #(.W(W)) u_cell_ab (
        .clk(clk), .rst_n(rst_n), .pass(ab_pass), .cap(ab_cap), .din(a_eff), .dout(ab_word)
    );

    xcvr_store_cell #(.W(W)) u_cell_ba (
        .clk(clk), .rst_n(rst_n), .pass(ba_pass), .cap(ba_cap), .din(b_eff), .dout(ba_word)
    );

    xcvr_out_stage #(.W(W), .EN_HIGH(1'b1)) u_out_b (
        .oe_pin(ab_oe), .data(ab_word), .pad_data(b_drv), .pad_en(b_drv_en)
    );

    xcvr_out_stage #(.W(W), .EN_HIGH(1'b0)) u_out_a (
        .oe_pin(ba_oe_n), .data(ba_word), .pad_data(a_drv), .pad_en(a_drv_en)
    );

    // Flag both directions driving at the same time.
    always_comb begin
        contention = ab_oe & ~ba_oe_n;
    end
endmodule

// File: rtl/xcvr_universal_chk.sv
// Checker for xcvr_universal: port-level temporal properties, attached by bind.
// Assumes: reset is held low for at least two clock edges at start.
module xcvr_universal_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ab_oe,
    input logic         ab_pass,
    input logic         ab_cap,
    input logic         ba_oe_n,
    input logic [W-1:0] a_in,
    input logic         a_in_en,
    input logic [W-1:0] b_drv,
    input logic         b_drv_en,
    input logic         a_drv_en,
    input logic         contention
);
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_pass && ab_oe && a_in_en) |-> (b_drv == a_in)); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && ab_oe && !$rose(ab_cap)) ##1 (!ab_pass && ab_oe) |-> $stable(b_drv)); // R3

    AST_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_pass && $rose(ab_cap) && a_in_en) ##1 (!ab_pass && ab_oe) |-> (b_drv == $past(a_in))); // R4

    AST_AB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe |-> (!b_drv_en && b_drv == '0)); // R6

    AST_BA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> !a_drv_en); // R7

    AST_KEEPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_in_en && ab_pass && ab_oe && $past(rst_n) && $past(ab_pass && ab_oe)) |-> $stable(b_drv)); // R8

    AST_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> (a_drv_en && b_drv_en)); // R11
endmodule

bind xcvr_universal xcvr_universal_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ab_oe(ab_oe), .ab_pass(ab_pass), .ab_cap(ab_cap),
    .ba_oe_n(ba_oe_n), .a_in(a_in), .a_in_en(a_in_en), .b_drv(b_drv),
    .b_drv_en(b_drv_en), .a_drv_en(a_drv_en), .contention(contention)
);

// File: tb/sim_xcvr_universal.sv
module sim_xcvr_universal;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_oe = 1'b0, ab_pass = 1'b0, ab_cap = 1'b0;
    logic         ba_oe_n = 1'b1, ba_pass = 1'b0, ba_cap = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_in_en = 1'b0, b_in_en = 1'b0;
    logic [W-1:0] a_drv, b_drv;
    logic         a_drv_en, b_drv_en, contention;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xcvr_universal #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ab_oe(ab_oe), .ab_pass(ab_pass), .ab_cap(ab_cap),
        .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_cap(ba_cap),
        .a_in(a_in), .a_in_en(a_in_en), .b_in(b_in), .b_in_en(b_in_en),
        .a_drv(a_drv), .a_drv_en(a_drv_en), .b_drv(b_drv), .b_drv_en(b_drv_en),
        .contention(contention)
    );

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 40503 + 341) ^ (i << 7));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge; return at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst_n = 1'b1;
        ab_oe = 1'b1;
        ba_oe_n = 1'b0;
        #1;

        // R10: storage cleared to zero by reset.
        chk("R10 ab store", b_drv, '0);
        chk("R10 ba store", a_drv, '0);
        ab_pass = 1'b1;
        #1;
        chk("R10 a keeper", b_drv, '0);

        // R1: walking one through each bit position.
        a_in_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            a_in = W'(1) << i;
            #1;
            chk("R1 walk", b_drv, W'(1) << i);
        end

        // R2 / R7: pass-through sweep in both directions.
        ba_pass = 1'b1;
        b_in_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            a_in = pat(i);
            b_in = ~pat(i + 3);
            #1;
            chk("R2 pass ab", b_drv, pat(i));
            chk("R7 pass ba", a_drv, ~pat(i + 3));
            tick();
        end

        // R3: hold after leaving pass mode.
        a_in = pat(100);
        tick();
        ab_pass = 1'b0;
        a_in = pat(101);
        tick();
        chk("R3 hold", b_drv, pat(100));

        // R4: rise of the capture pin stores A.
        ab_cap = 1'b1;
        a_in = pat(102);
        tick();
        chk("R4 load", b_drv, pat(102));

        // R3: capture pin stays high, no new load.
        a_in = pat(103);
        tick();
        chk("R3 cap steady high", b_drv, pat(102));

        // R5: a fall does not load.
        ab_cap = 1'b0;
        a_in = pat(104);
        tick();
        chk("R5 fall", b_drv, pat(102));

        // R6: disabled output released and zero.
        ab_oe = 1'b0;
        #1;
        chk("R6 en off", {17'd0, b_drv_en}, '0);
        chk("R6 data zero", b_drv, '0);

        // R9: capture while disabled, then re-enable.
        ab_cap = 1'b1;
        a_in = pat(105);
        tick();
        ab_cap = 1'b0;
        tick();
        ab_oe = 1'b1;
        #1;
        chk("R9 stored while off", b_drv, pat(105));

        // R7: B-to-A hold / load / fall sequence.
        b_in = pat(200);
        tick();
        ba_pass = 1'b0;
        b_in = pat(201);
        tick();
        chk("R7 ba hold", a_drv, pat(200));
        ba_cap = 1'b1;
        b_in = pat(202);
        tick();
        chk("R7 ba load", a_drv, pat(202));
        ba_cap = 1'b0;
        b_in = pat(203);
        tick();
        chk("R7 ba fall", a_drv, pat(202));

        // R8: bus-hold keeps last driven level.
        ab_pass = 1'b1;
        a_in = pat(300);
        tick();
        a_in_en = 1'b0;
        a_in = pat(301);
        #1;
        chk("R8 keeper now", b_drv, pat(300));
        tick();
        chk("R8 keeper later", b_drv, pat(300));
        ab_pass = 1'b0;
        ab_cap = 1'b1;
        tick();
        chk("R8 keeper captured", b_drv, pat(300));
        ab_cap = 1'b0;

        // R6 / R7 / R11: all enable combinations.
        for (int k = 0; k < 4; k++) begin
            ab_oe = k[0];
            ba_oe_n = k[1];
            #1;
            chk("R6 b_drv_en", {17'd0, b_drv_en}, W'(k[0]));
            chk("R7 a_drv_en", {17'd0, a_drv_en}, W'(!k[1]));
            chk("R11 contention", {17'd0, contention}, W'(k[0] && !k[1]));
            tick();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule